// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. A sampling tick, one system clock wide, runs at 16 or 64 times the bit rate. The block first qualifies a falling edge on the line as a genuine start bit. It then takes every following bit at its centre and assembles a character of 5 to 8 data bits, least significant bit first. After the data bits it checks an optional parity bit and the first stop bit.

A delivered character is held on `rx_data` and announced by `rx_rdy` until a single-cycle read pulse takes it. Parity, framing and overrun problems raise sticky flags, and these stay set until an error-clear pulse. A line held at space across the stop positions of two consecutive frames raises `brk_det`, which drops as soon as the line returns to mark. Frames made entirely of space bits are never delivered as characters.

The serial input is taken to be already synchronous to `clk`. The configuration inputs are expected to change only while the line is idle.

Top module: `orx_receiver`

## Requirements
- R1: In the 16x setting, a low level on `rxd` lasting fewer than 8 consecutive ticks is ignored and leaves the receiver idle. In the 64x setting (`fac_sel`=1) the limit is 32 ticks.
- R2: A low level lasting at least half a bit time (8 ticks at 16x, 32 ticks at 64x) is accepted as a start bit. A start bit of exactly half a bit time is also accepted, and the frame that follows is received normally.
- R3: The first data bit is sampled one full bit time (16 or 64 ticks) after start confirmation, and each later bit one full bit time after the one before. Data is assembled LSB first. `len_sel` = 0, 1, 2, 3 selects 5, 6, 7, 8 data bits, and unused upper bits of `rx_data` read as zero.
- R4: With `par_en`=1, a parity bit follows the data bits. `par_even`=1 expects an even total count of ones over data plus parity, and `par_even`=0 expects an odd count. A mismatch on a delivered character sets `par_err`.
- R5: A stop bit sampled low sets `frm_err`.
- R6: If a character is delivered while `rx_rdy` is still set and not being read, `ovr_err` is set and `rx_data` takes the new character.
- R7: A `rd_pulse` clears `rx_rdy` on the next cycle, unless a new character is delivered in that same cycle.
- R8: `par_err`, `frm_err` and `ovr_err` stay set until an `err_clr` pulse clears them.
- R9: `brk_det` rises when the stop bits of two consecutive frames are sampled low with no high level on `rxd` in between. It falls in the cycle after `rxd` is high, and it is low after reset.
- R10: A frame whose data, parity and stop bits are all low is not delivered. It leaves `rx_rdy`, `rx_data` and `par_err` unchanged.
- R11: While `rx_en` is low, the receiver stays idle and delivers no character.
- R12: After reset, `rx_rdy`, all error flags, `brk_det` and `rx_data` are zero.
- R13: In the 64x setting, the whole frame timing scales to 64 ticks per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| samp_tick | input | 1 | Oversampling tick, one clock wide |
| rxd | input | 1 | Serial line, high is mark |
| rx_en | input | 1 | Receive enable |
| len_sel | input | 2 | Data length: 0..3 selects 5..8 bits |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 selects even parity, 0 selects odd parity |
| fac_sel | input | 1 | 0 selects 16x oversampling, 1 selects 64x |
| rd_pulse | input | 1 | Host has taken the character |
| err_clr | input | 1 | Clears the sticky error flags |
| rx_data | output | 8 | Last delivered character |
| rx_rdy | output | 1 | Character waiting to be read |
| par_err | output | 1 | Sticky parity error |
| frm_err | output | 1 | Sticky framing error |
| ovr_err | output | 1 | Sticky overrun error |
| brk_det | output | 1 | Break condition on the line |

## Verification
The assertions assume that the format and factor inputs are stable for the whole frame. They also assume that `rd_pulse` and `err_clr` are single-cycle pulses and that `rxd` only changes between clock edges. The bench holds the tick high and changes the format only while the line idles at mark. It drives every serial level and pulse on the falling clock edge. A bad stop bit is held low only a few ticks past its centre, so that its tail cannot qualify as a new start bit.

// File: rtl/orx_pkg.sv
package orx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_START = 3'd1,
        RX_DATA  = 3'd2,
        RX_PAR   = 3'd3,
        RX_STOP  = 3'd4
    } rx_state_e;

endpackage

// File: rtl/orx_frame_fsm.sv
module orx_frame_fsm
    import orx_pkg::*;
#(
    parameter int unsigned MAX_BITS = 8,
    parameter int unsigned OVS_LO   = 16,
    parameter int unsigned OVS_HI   = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                samp_tick,
    input  logic                rxd,
    input  logic                rx_en,
    input  logic [1:0]          len_sel,
    input  logic                par_en,
    input  logic                par_even,
    input  logic                fac_sel,
    output logic                done,
    output logic [MAX_BITS-1:0] data,
    output logic                par_bad,
    output logic                stop_bad,
    output logic                all_space
);
    localparam int unsigned CNT_W = $clog2(OVS_HI);
    localparam int unsigned IDX_W = $clog2(MAX_BITS);
    localparam logic [CNT_W-1:0] LO_HALF_M1 = CNT_W'(OVS_LO / 2 - 1);
    localparam logic [CNT_W-1:0] HI_HALF_M1 = CNT_W'(OVS_HI / 2 - 1);
    localparam logic [CNT_W-1:0] LO_FULL_M1 = CNT_W'(OVS_LO - 1);
    localparam logic [CNT_W-1:0] HI_FULL_M1 = CNT_W'(OVS_HI - 1);
    localparam logic [IDX_W-1:0] SHORTEST_M1 = IDX_W'(MAX_BITS - 4);

    typedef struct packed {
        rx_state_e             st;
        logic [CNT_W-1:0]      cnt;
        logic [IDX_W-1:0]      idx;
        logic [MAX_BITS-1:0]   sh;
        logic                  pbit;
    } fsm_s;

    fsm_s q, d;
    logic done_c;
    logic [CNT_W-1:0] half_m1, full_m1;
    logic [IDX_W-1:0] last_idx;

    assign half_m1  = fac_sel ? HI_HALF_M1 : LO_HALF_M1;
    assign full_m1  = fac_sel ? HI_FULL_M1 : LO_FULL_M1;
    assign last_idx = SHORTEST_M1 + IDX_W'(len_sel);

    always_comb begin
        d      = q;
        done_c = 1'b0;
        case (q.st)
            RX_IDLE: begin
                if (samp_tick && !rxd) begin
                    d.st  = RX_START;
                    d.cnt = CNT_W'(1);
                end
            end
            RX_START: begin
                if (samp_tick) begin
                    if (rxd) begin
                        d.st = RX_IDLE;
                    end else if (q.cnt == half_m1) begin
                        d.st  = RX_DATA;
                        d.cnt = '0;
                        d.idx = '0;
                        d.sh  = '0;
                        d.pbit = 1'b0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (samp_tick) begin
                    if (q.cnt == full_m1) begin
                        d.cnt        = '0;
                        d.sh[q.idx]  = rxd;
                        if (q.idx == last_idx) begin
                            d.st = par_en ? RX_PAR : RX_STOP;
                        end else begin
                            d.idx = q.idx + 1'b1;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            RX_PAR: begin
                if (samp_tick) begin
                    if (q.cnt == full_m1) begin
                        d.cnt  = '0;
                        d.pbit = rxd;
                        d.st   = RX_STOP;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            RX_STOP: begin
                if (samp_tick) begin
                    if (q.cnt == full_m1) begin
                        done_c = 1'b1;
                        d.cnt  = '0;
                        d.st   = RX_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: d.st = RX_IDLE;
        endcase
        if (!rx_en) begin
            d.st  = RX_IDLE;
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= RX_IDLE;
            q.cnt  <= '0;
            q.idx  <= '0;
            q.sh   <= '0;
            q.pbit <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign done      = done_c & rx_en;
    assign data      = q.sh;
    assign stop_bad  = ~rxd;
    assign par_bad   = par_en & (^q.sh ^ q.pbit ^ ~par_even);
    assign all_space = (q.sh == '0) & ~(par_en & q.pbit) & ~rxd;

    // R1: a start candidate that sees mark again goes back to idle
    assert_start_glitch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == RX_START && samp_tick && rxd && rx_en) |=> (q.st == RX_IDLE));

    // R3: bits above the selected length are never filled
    assert_zero_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((data >> ({1'b0, last_idx} + 1'b1)) == '0));

    // R11: a disabled receiver sits in idle
    assert_idle_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (q.st == RX_IDLE));

endmodule

// File: rtl/orx_flags.sv
module orx_flags #(
    parameter int unsigned MAX_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rxd,
    input  logic                done,
    input  logic [MAX_BITS-1:0] data_in,
    input  logic                par_bad,
    input  logic                stop_bad,
    input  logic                all_space,
    input  logic                rd_pulse,
    input  logic                err_clr,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_rdy,
    output logic                par_err,
    output logic                frm_err,
    output logic                ovr_err,
    output logic                brk_det
);
    typedef struct packed {
        logic [MAX_BITS-1:0] dat;
        logic                rdy;
        logic                par;
        logic                frm;
        logic                ovr;
        logic                run;
        logic                brk;
    } flag_s;

    flag_s q, d;
    logic  deliver;

    assign deliver = done & ~all_space;

    always_comb begin
        d = q;
        if (rd_pulse) d.rdy = 1'b0;
        if (err_clr) begin
            d.par = 1'b0;
            d.frm = 1'b0;
            d.ovr = 1'b0;
        end
        if (done && stop_bad) d.frm = 1'b1;
        if (deliver) begin
            d.dat = data_in;
            d.rdy = 1'b1;
            if (par_bad) d.par = 1'b1;
            if (q.rdy && !rd_pulse) d.ovr = 1'b1;
        end
        if (rxd) begin
            d.run = 1'b0;
            d.brk = 1'b0;
        end else if (done && stop_bad) begin
            if (q.run) d.brk = 1'b1;
            d.run = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rx_data = q.dat;
    assign rx_rdy  = q.rdy;
    assign par_err = q.par;
    assign frm_err = q.frm;
    assign ovr_err = q.ovr;
    assign brk_det = q.brk;

    // R6: delivery over an unread character flags overrun
    assert_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver && rx_rdy && !rd_pulse) |=> ovr_err);

    // R7: a read without a new arrival empties the holding register
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pulse && !deliver) |=> !rx_rdy);

    // R8: framing flag survives until cleared
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_err && !err_clr) |=> frm_err);

    // R9: mark on the line ends a break indication
    assert_brk_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rxd |=> !brk_det);

    // R10: an all-space frame never raises the ready flag
    assert_space_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && all_space && !rx_rdy) |=> !rx_rdy);

endmodule

// File: rtl/orx_receiver.sv
module orx_receiver #(
    parameter int unsigned MAX_BITS = 8,
    parameter int unsigned OVS_LO   = 16,
    parameter int unsigned OVS_HI   = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                samp_tick,
    input  logic                rxd,
    input  logic                rx_en,
    input  logic [1:0]          len_sel,
    input  logic                par_en,
    input  logic                par_even,
    input  logic                fac_sel,
    input  logic                rd_pulse,
    input  logic                err_clr,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_rdy,
    output logic                par_err,
    output logic                frm_err,
    output logic                ovr_err,
    output logic                brk_det
);
    logic                done;
    logic [MAX_BITS-1:0] data;
    logic                par_bad;
    logic                stop_bad;
    logic                all_space;

    orx_frame_fsm #(
        .MAX_BITS (MAX_BITS),
        .OVS_LO   (OVS_LO),
        .OVS_HI   (OVS_HI)
    ) i_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp_tick (samp_tick),
        .rxd       (rxd),
        .rx_en     (rx_en),
        .len_sel   (len_sel),
        .par_en    (par_en),
        .par_even  (par_even),
        .fac_sel   (fac_sel),
        .done      (done),
        .data      (data),
        .par_bad   (par_bad),
        .stop_bad  (stop_bad),
        .all_space (all_space)
    );

    orx_flags #(
        .MAX_BITS (MAX_BITS)
    ) i_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .rxd       (rxd),
        .done      (done),
        .data_in   (data),
        .par_bad   (par_bad),
        .stop_bad  (stop_bad),
        .all_space (all_space),
        .rd_pulse  (rd_pulse),
        .err_clr   (err_clr),
        .rx_data   (rx_data),
        .rx_rdy    (rx_rdy),
        .par_err   (par_err),
        .frm_err   (frm_err),
        .ovr_err   (ovr_err),
        .brk_det   (brk_det)
    );

endmodule

// File: tb/test_orx_receiver.sv
module test_orx_receiver;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       samp_tick = 1'b1;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b1;
    logic [1:0] len_sel = 2'd3;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic       fac_sel = 1'b0;
    logic       rd_pulse = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_rdy, par_err, frm_err, ovr_err, brk_det;

    int checks = 0;
    int errors = 0;

    orx_receiver i_orx_receiver (
        .clk(clk), .rst_n(rst_n), .samp_tick(samp_tick), .rxd(rxd), .rx_en(rx_en),
        .len_sel(len_sel), .par_en(par_en), .par_even(par_even), .fac_sel(fac_sel),
        .rd_pulse(rd_pulse), .err_clr(err_clr), .rx_data(rx_data), .rx_rdy(rx_rdy),
        .par_err(par_err), .frm_err(frm_err), .ovr_err(ovr_err), .brk_det(brk_det)
    );

    function automatic logic [7:0] mask_len(input logic [7:0] v, input logic [1:0] ls);
        int n = 5 + int'(ls);
        return v & 8'((1 << n) - 1);
    endfunction

    function automatic logic exp_parity(input logic [7:0] v, input logic even);
        return even ? ^v : ~^v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] v, input logic flip_par, input logic stop_ok);
        int ovs = fac_sel ? 64 : 16;
        int n = 5 + int'(len_sel);
        logic [7:0] m = mask_len(v, len_sel);
        hold(1'b0, ovs);
        for (int i = 0; i < n; i++) hold(m[i], ovs);
        if (par_en) hold(exp_parity(m, par_even) ^ flip_par, ovs);
        if (stop_ok) hold(1'b1, ovs);
        else hold(1'b0, ovs / 2 + 2);
        hold(1'b1, 6);
    endtask

    task automatic pulse_rd();
        rd_pulse = 1'b1;
        @(negedge clk);
        rd_pulse = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R12 actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (6) @(negedge clk);
        // R12 reset state
        chk("R12 rx_rdy", rx_rdy, 0);
        chk("R12 flags", {par_err, frm_err, ovr_err}, 0);
        chk("R12 rx_data", rx_data, 0);
        chk("R9 brk after reset", brk_det, 0);
        rst_n = 1'b1;
        hold(1'b1, 4);

        // R3 directed 8-bit frame
        send_frame(8'hA5, 1'b0, 1'b1);
        chk("R3 data A5", rx_data, 8'hA5);
        chk("R3 rdy", rx_rdy, 1);
        pulse_rd();
        chk("R7 rdy after read", rx_rdy, 0);

        // R3 zero fill on 5-bit
        len_sel = 2'd0;
        send_frame(8'hFF, 1'b0, 1'b1);
        chk("R3 zero fill", rx_data, 8'h1F);
        pulse_rd();

        // random frames, R3 R4 R13
        for (int k = 0; k < 24; k++) begin
            logic [7:0] v = 8'($urandom);
            len_sel  = 2'($urandom);
            par_en   = 1'($urandom);
            par_even = 1'($urandom);
            fac_sel  = ($urandom % 4) == 0;
            send_frame(v, 1'b0, 1'b1);
            chk(fac_sel ? "R13 random data" : "R3 random data", rx_data, mask_len(v, len_sel));
            chk("R4 no parity error", par_err, 0);
            chk("R5 no framing error", frm_err, 0);
            chk("R3 random rdy", rx_rdy, 1);
            pulse_rd();
            chk("R7 random read", rx_rdy, 0);
        end
        chk("R6 no spurious overrun", ovr_err, 0);

        // R4 parity error and R8 stickiness
        fac_sel = 1'b0; len_sel = 2'd3; par_en = 1'b1; par_even = 1'b1;
        send_frame(8'h3B, 1'b1, 1'b1);
        chk("R4 parity error set", par_err, 1);
        chk("R4 char still delivered", rx_rdy, 1);
        pulse_rd();
        send_frame(8'h11, 1'b0, 1'b1);
        chk("R8 parity flag sticky", par_err, 1);
        pulse_rd();
        pulse_clr();
        chk("R8 cleared", par_err, 0);

        // R5 framing
        par_en = 1'b0;
        send_frame(8'h3C, 1'b0, 1'b0);
        chk("R5 framing set", frm_err, 1);
        chk("R5 data", rx_data, 8'h3C);
        pulse_rd();
        pulse_clr();
        chk("R8 framing cleared", frm_err, 0);

        // R6 overrun
        send_frame(8'h12, 1'b0, 1'b1);
        send_frame(8'h34, 1'b0, 1'b1);
        chk("R6 overrun set", ovr_err, 1);
        chk("R6 newest data", rx_data, 8'h34);
        pulse_rd();
        pulse_clr();
        chk("R8 overrun cleared", ovr_err, 0);

        // R1 short start, R2 half-bit start (16x)
        hold(1'b0, 7);
        hold(1'b1, 200);
        chk("R1 short start ignored", rx_rdy, 0);
        hold(1'b0, 8);
        hold(1'b1, 200);
        chk("R2 half start accepted", rx_rdy, 1);
        chk("R2 half start data", rx_data, 8'hFF);
        pulse_rd();

        // R1 R2 R13 at 64x
        fac_sel = 1'b1; len_sel = 2'd0;
        hold(1'b0, 31);
        hold(1'b1, 500);
        chk("R1 short start 64x", rx_rdy, 0);
        hold(1'b0, 32);
        hold(1'b1, 500);
        chk("R13 half start 64x", rx_rdy, 1);
        chk("R13 data 64x", rx_data, 8'h1F);
        pulse_rd();

        // R9 R10 break
        fac_sel = 1'b0; len_sel = 2'd3; par_en = 1'b1; par_even = 1'b0;
        pulse_clr();
        hold(1'b0, 340);
        chk("R9 break detected", brk_det, 1);
        chk("R10 no delivery on break", rx_rdy, 0);
        chk("R10 no parity from break", par_err, 0);
        chk("R5 break framing", frm_err, 1);
        hold(1'b1, 1);
        chk("R9 break released", brk_det, 0);
        hold(1'b1, 20);
        pulse_clr();
        send_frame(8'h5A, 1'b0, 1'b1);
        chk("R10 next char rdy", rx_rdy, 1);
        chk("R10 next char clean parity", par_err, 0);
        chk("R10 next char data", rx_data, 8'h5A);
        pulse_rd();

        // R11 receive disabled
        rx_en = 1'b0;
        send_frame(8'h77, 1'b0, 1'b1);
        chk("R11 disabled no rdy", rx_rdy, 0);
        chk("R11 disabled data kept", rx_data, 8'h5A);
        rx_en = 1'b1;
        hold(1'b1, 4);
        send_frame(8'h77, 1'b0, 1'b1);
        chk("R11 enabled again", rx_data, 8'h77);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule